// File: doc/BRIEF.md
# Configurable Edge/Level Interrupt Controller

This block gathers up to 32 interrupt sources into two prioritised request lines and one wake request line. Each source has its own trigger mode, held as one bit in each of three configuration planes. The mode picks the trigger: no trigger, rising edge, falling edge, both edges, active-high level or active-low level. Each source input passes through a synchroniser before it is examined. Edges are caught in separate rising and falling status registers that software acknowledges. Level sources are reported straight from the synchronised input.

A mask bit gates each source into the pending registers. A route bit steers each source to request output 0, which is serviced first, or to request output 1. A wake-enable bit, tied to the mask by hardware, selects the sources that drive the wake request. Software changes every control register through a pair of word addresses. One address sets the bits written as 1 and the other clears them, so no read-modify-write is ever needed. A readback address returns each register, so the whole state can be saved and restored.

The register port is a plain single-cycle write strobe with a combinational read. Every access completes in its cycle, so the port has no stall and no back-pressure.

Top module: `edge_level_intc`

## Requirements
- R1: After reset, the three configuration planes, mask, route, wake and both edge status registers read 0. The source-select register reads all ones, the test register reads 0, and req0_o, req1_o and wake_o are low.
- R2: A source's mode is {plane2,plane1,plane0}. The codes are 000 no trigger, 001 rising edge, 010 falling edge, 011 both edges, 101 active-high level and 110 active-low level. Codes 100 and 111 never make a source pending.
- R3: Control register group g has its readback at word address 3g, its set address at 3g+1 and its clear address at 3g+2. The groups are 0 plane0, 1 plane1, 2 plane2, 3 route, 4 wake, 5 mask and 6 source-select. Bits written as 1 set or clear; bits written as 0 leave the register unchanged.
- R4: A synchronised rising (falling) transition is latched in the rising status register (word 21) or the falling status register (word 23), but only if the source's mode enables that edge. Writing 1s to word 22 (rising) or word 24 (falling) clears the matching bits. Writing 1s to word 25 clears both edge bits of those sources. An edge that arrives in the same cycle as a clear of its bit stays latched.
- R5: A source is pending only when its mask bit is 1. Setting mask bits also sets the same wake bits, and clearing mask bits also clears them.
- R6: Pending sources with route bit 1 appear in pending register 0 (word 26) and drive req0_o. Pending sources with route bit 0 appear in pending register 1 (word 27) and drive req1_o. Each request output is the OR of its pending register.
- R7: A level source's pending bit follows the synchronised input directly (inverted for active-low) and is not latched. An input change reaches the pending register after two clock edges. An edge reaches the status register after three clock edges.
- R8: wake_o is the OR, over all wake-enabled sources, of the pending value taken before masking.
- R9: Word 28 is a read/write test register. Reads of unmapped words return 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_i | input | 32 | Asynchronous interrupt source inputs |
| bus_we | input | 1 | Write strobe; the write takes effect at the clock edge |
| bus_addr | input | 5 | Word address for read and write |
| bus_wdata | input | 32 | Write data, one bit per source |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| req0_o | output | 1 | Request output 0, serviced first |
| req1_o | output | 1 | Request output 1 |
| wake_o | output | 1 | Wake request |

## Verification
A corrupted configuration, mask or route bit makes a source land in the wrong pending register, or in none. This shows on the pending readback and on req0_o/req1_o within two edges for level sources and within three edges for edge sources. A latch that drops or invents an edge bit shows on the status readback three edges after the input moves, and it stays wrong until software acknowledges it. The bench drives all 32 sources at once with all eight mode codes repeated across them. It compares every readback and every output against a model kept in the bench.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int NGRP     = 7;
  localparam int G_CFG0   = 0;
  localparam int G_CFG1   = 1;
  localparam int G_CFG2   = 2;
  localparam int G_ROUTE  = 3;
  localparam int G_WAKE   = 4;
  localparam int G_MASK   = 5;
  localparam int G_SEL    = 6;
  localparam int OFS_RISE     = 3 * NGRP;
  localparam int OFS_RISE_CLR = OFS_RISE + 1;
  localparam int OFS_FALL     = OFS_RISE + 2;
  localparam int OFS_FALL_CLR = OFS_RISE + 3;
  localparam int OFS_ACK      = OFS_RISE + 4;
  localparam int OFS_PEND0    = OFS_RISE + 5;
  localparam int OFS_PEND1    = OFS_RISE + 6;
  localparam int OFS_TEST     = OFS_RISE + 7;

  typedef enum logic [2:0] {
    TRIG_OFF  = 3'b000,
    TRIG_RISE = 3'b001,
    TRIG_FALL = 3'b010,
    TRIG_BOTH = 3'b011,
    TRIG_HIGH = 3'b101,
    TRIG_LOW  = 3'b110
  } trig_e;
endpackage

// File: rtl/intc_setclr_reg.sv
module intc_setclr_reg #(
  parameter int W        = 32,
  parameter bit RST_ONES = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_v,
  input  logic [W-1:0] clr_v,
  output logic [W-1:0] q
);
  localparam logic [W-1:0] RST_VAL = RST_ONES ? {W{1'b1}} : {W{1'b0}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= RST_VAL;
    else        q <= (q & ~clr_v) | set_v;
  end

  AST_UNTOUCHED_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (((q ^ $past(q)) & ~($past(set_v) | $past(clr_v))) == '0)); // R3
  AST_SET_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    ((set_v != '0) |=> ((q & $past(set_v)) == $past(set_v)))); // R3
endmodule

// File: rtl/intc_edge_unit.sv
module intc_edge_unit #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] src_i,
  input  logic [W-1:0] en_rise,
  input  logic [W-1:0] en_fall,
  input  logic [W-1:0] rise_clr,
  input  logic [W-1:0] fall_clr,
  output logic [W-1:0] lvl_o,
  output logic [W-1:0] rise_q,
  output logic [W-1:0] fall_q
);
  logic [STAGES-1:0][W-1:0] stg;
  logic [W-1:0] lvl_d;
  logic [W-1:0] rise_ev, fall_ev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg   <= '0;
      lvl_d <= '0;
    end else begin
      stg[0] <= src_i;
      for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
      lvl_d <= stg[STAGES-1];
    end
  end

  assign lvl_o   = stg[STAGES-1];
  assign rise_ev = lvl_o & ~lvl_d & en_rise;
  assign fall_ev = ~lvl_o & lvl_d & en_fall;

  // the event term is ORed after the clear, so an edge in the clear cycle survives
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rise_q <= '0;
      fall_q <= '0;
    end else begin
      rise_q <= (rise_q & ~rise_clr) | rise_ev;
      fall_q <= (fall_q & ~fall_clr) | fall_ev;
    end
  end

  AST_RISE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ((($past(rise_q) & ~rise_q) & ~$past(rise_clr)) == '0)); // R4
  AST_FALL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ((($past(fall_q) & ~fall_q) & ~$past(fall_clr)) == '0)); // R4
  AST_RISE_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    ((rise_q & ~$past(rise_q) & ~$past(en_rise)) == '0)); // R4
  AST_FALL_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    ((fall_q & ~$past(fall_q) & ~$past(en_fall)) == '0)); // R4
endmodule

// File: rtl/intc_trigger_decode.sv
module intc_trigger_decode
  import intc_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] cfg0,
  input  logic [W-1:0] cfg1,
  input  logic [W-1:0] cfg2,
  input  logic [W-1:0] lvl,
  input  logic [W-1:0] rise_q,
  input  logic [W-1:0] fall_q,
  output logic [W-1:0] en_rise,
  output logic [W-1:0] en_fall,
  output logic [W-1:0] raw_pend
);
  for (genvar i = 0; i < W; i++) begin : g_src
    logic [2:0] mode;
    assign mode = {cfg2[i], cfg1[i], cfg0[i]};
    always_comb begin
      en_rise[i]  = 1'b0;
      en_fall[i]  = 1'b0;
      raw_pend[i] = 1'b0;
      case (mode)
        TRIG_RISE: begin en_rise[i] = 1'b1; raw_pend[i] = rise_q[i]; end
        TRIG_FALL: begin en_fall[i] = 1'b1; raw_pend[i] = fall_q[i]; end
        TRIG_BOTH: begin
          en_rise[i]  = 1'b1;
          en_fall[i]  = 1'b1;
          raw_pend[i] = rise_q[i] | fall_q[i];
        end
        TRIG_HIGH: raw_pend[i] = lvl[i];
        TRIG_LOW:  raw_pend[i] = ~lvl[i];
        default:   raw_pend[i] = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/edge_level_intc.sv
module edge_level_intc
  import intc_pkg::*;
#(
  parameter int NSRC        = 32,
  parameter int ADDR_W      = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   src_i,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [NSRC-1:0]   bus_wdata,
  output logic [NSRC-1:0]   bus_rdata,
  output logic              req0_o,
  output logic              req1_o,
  output logic              wake_o
);
  logic [NSRC-1:0] grp_q   [NGRP];
  logic [NSRC-1:0] grp_set [NGRP];
  logic [NSRC-1:0] grp_clr [NGRP];
  logic [NSRC-1:0] mask_q, wake_q, route_q;
  logic [NSRC-1:0] lvl, rise_q, fall_q, en_rise, en_fall, raw_pend;
  logic [NSRC-1:0] rise_clr, fall_clr, pend_all, pend0, pend1;
  logic [NSRC-1:0] test_q;

  function automatic logic hit(input logic [ADDR_W-1:0] a, input int ofs);
    return a == ADDR_W'(ofs);
  endfunction

  // set/clear strobes; mask writes are mirrored into the wake group
  always_comb begin
    for (int g = 0; g < NGRP; g++) begin
      grp_set[g] = (bus_we && hit(bus_addr, 3*g + 1)) ? bus_wdata : '0;
      grp_clr[g] = (bus_we && hit(bus_addr, 3*g + 2)) ? bus_wdata : '0;
    end
    grp_set[G_WAKE] = grp_set[G_WAKE] | grp_set[G_MASK];
    grp_clr[G_WAKE] = grp_clr[G_WAKE] | grp_clr[G_MASK];
  end

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    intc_setclr_reg #(.W(NSRC), .RST_ONES(g == G_SEL)) u_reg (
      .clk   (clk),
      .rst_n (rst_n),
      .set_v (grp_set[g]),
      .clr_v (grp_clr[g]),
      .q     (grp_q[g])
    );
  end

  assign mask_q  = grp_q[G_MASK];
  assign wake_q  = grp_q[G_WAKE];
  assign route_q = grp_q[G_ROUTE];

  always_comb begin
    rise_clr = '0;
    fall_clr = '0;
    if (bus_we && (hit(bus_addr, OFS_RISE_CLR) || hit(bus_addr, OFS_ACK))) rise_clr = bus_wdata;
    if (bus_we && (hit(bus_addr, OFS_FALL_CLR) || hit(bus_addr, OFS_ACK))) fall_clr = bus_wdata;
  end

  intc_edge_unit #(.W(NSRC), .STAGES(SYNC_STAGES)) u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .src_i    (src_i),
    .en_rise  (en_rise),
    .en_fall  (en_fall),
    .rise_clr (rise_clr),
    .fall_clr (fall_clr),
    .lvl_o    (lvl),
    .rise_q   (rise_q),
    .fall_q   (fall_q)
  );

  intc_trigger_decode #(.W(NSRC)) u_dec (
    .cfg0     (grp_q[G_CFG0]),
    .cfg1     (grp_q[G_CFG1]),
    .cfg2     (grp_q[G_CFG2]),
    .lvl      (lvl),
    .rise_q   (rise_q),
    .fall_q   (fall_q),
    .en_rise  (en_rise),
    .en_fall  (en_fall),
    .raw_pend (raw_pend)
  );

  assign pend_all = raw_pend & mask_q;
  assign pend0    = pend_all & route_q;
  assign pend1    = pend_all & ~route_q;
  assign req0_o   = |pend0;
  assign req1_o   = |pend1;
  assign wake_o   = |(raw_pend & wake_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                               test_q <= '0;
    else if (bus_we && hit(bus_addr, OFS_TEST)) test_q <= bus_wdata;
  end

  always_comb begin
    bus_rdata = '0;
    for (int g = 0; g < NGRP; g++)
      if (hit(bus_addr, 3*g)) bus_rdata = grp_q[g];
    if (hit(bus_addr, OFS_RISE))  bus_rdata = rise_q;
    if (hit(bus_addr, OFS_FALL))  bus_rdata = fall_q;
    if (hit(bus_addr, OFS_PEND0)) bus_rdata = pend0;
    if (hit(bus_addr, OFS_PEND1)) bus_rdata = pend1;
    if (hit(bus_addr, OFS_TEST))  bus_rdata = test_q;
  end

  AST_MASK_CLR_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
    ((bus_we && hit(bus_addr, 3*G_MASK + 2)) |=> ((wake_q & $past(bus_wdata)) == '0))); // R5
  AST_MASK_SET_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
    ((bus_we && hit(bus_addr, 3*G_MASK + 1)) |=> ((wake_q & $past(bus_wdata)) == $past(bus_wdata)))); // R5
  AST_REQ0_ROUTED: assert property (@(posedge clk) disable iff (!rst_n)
    (req0_o |-> ((mask_q & route_q) != '0))); // R6
  AST_REQ1_ROUTED: assert property (@(posedge clk) disable iff (!rst_n)
    (req1_o |-> ((mask_q & ~route_q) != '0))); // R6
  AST_WAKE_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_o |-> (wake_q != '0))); // R8
endmodule

// File: tb/edge_level_intc_tb.sv
module edge_level_intc_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src_i = '0;
  logic        bus_we = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        req0_o, req1_o, wake_o;

  int checks = 0;
  int fails  = 0;

  logic [31:0] m_grp [7];
  logic [31:0] m_rise, m_fall, m_src;

  edge_level_intc u_dut (
    .clk(clk), .rst_n(rst_n), .src_i(src_i), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .req0_o(req0_o), .req1_o(req1_o), .wake_o(wake_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    tick();
    bus_we = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [4:0] a, input logic [31:0] exp, input string tag);
    bus_addr = a;
    #1;
    chk(tag, bus_rdata, exp);
  endtask

  // model writes to a set (sc=1) or clear (sc=0) address of group g
  task automatic mwr(input int g, input bit sc, input logic [31:0] d);
    wr(5'(3*g + (sc ? 1 : 2)), d);
    if (sc) m_grp[g] = m_grp[g] | d; else m_grp[g] = m_grp[g] & ~d;
    if (g == 5) begin
      if (sc) m_grp[4] = m_grp[4] | d; else m_grp[4] = m_grp[4] & ~d;
    end
  endtask

  function automatic logic [2:0] mode_of(input int i);
    return {m_grp[2][i], m_grp[1][i], m_grp[0][i]};
  endfunction

  function automatic logic [31:0] exp_raw();
    logic [31:0] r = '0;
    for (int i = 0; i < 32; i++) begin
      case (mode_of(i))
        3'b001: r[i] = m_rise[i];
        3'b010: r[i] = m_fall[i];
        3'b011: r[i] = m_rise[i] | m_fall[i];
        3'b101: r[i] = m_src[i];
        3'b110: r[i] = ~m_src[i];
        default: r[i] = 1'b0;
      endcase
    end
    return r;
  endfunction

  task automatic apply(input logic [31:0] v);
    src_i = v;
    repeat (3) tick();
    for (int i = 0; i < 32; i++) begin
      logic [2:0] m = mode_of(i);
      if ((m == 3'b001 || m == 3'b011) && !m_src[i] && v[i]) m_rise[i] = 1'b1;
      if ((m == 3'b010 || m == 3'b011) && m_src[i] && !v[i]) m_fall[i] = 1'b1;
    end
    m_src = v;
  endtask

  task automatic check_all(input string tag);
    logic [31:0] raw = exp_raw();
    logic [31:0] p   = raw & m_grp[5];
    rd(5'd21, m_rise, {tag, " R4 rise status"});
    rd(5'd23, m_fall, {tag, " R4 fall status"});
    rd(5'd26, p & m_grp[3], {tag, " R2 R6 pending0"});
    rd(5'd27, p & ~m_grp[3], {tag, " R5 R6 pending1"});
    chk({tag, " R6 req0"}, {31'd0, req0_o}, {31'd0, |(p & m_grp[3])});
    chk({tag, " R6 req1"}, {31'd0, req1_o}, {31'd0, |(p & ~m_grp[3])});
    chk({tag, " R8 wake"}, {31'd0, wake_o}, {31'd0, |(raw & m_grp[4])});
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int g = 0; g < 7; g++) m_grp[g] = (g == 6) ? 32'hFFFF_FFFF : 32'h0;
    m_rise = '0; m_fall = '0; m_src = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tick();

    // R1 reset state
    for (int g = 0; g < 7; g++) rd(5'(3*g), m_grp[g], "R1 reset readback");
    rd(5'd21, 32'h0, "R1 reset rise");
    rd(5'd23, 32'h0, "R1 reset fall");
    rd(5'd28, 32'h0, "R1 reset test reg");
    chk("R1 reset outputs", {29'd0, req0_o, req1_o, wake_o}, 32'h0);

    // R3 set/clear sweep over every group, R5 wake coupling
    for (int g = 0; g < 7; g++) begin
      mwr(g, 1'b1, 32'h0F0F_1234 ^ (32'h1111_1111 * g));
      mwr(g, 1'b0, 32'h00FF_00F3 << g);
      for (int k = 0; k < 7; k++) rd(5'(3*k), m_grp[k], "R3 R5 set/clear readback");
    end
    for (int g = 0; g < 7; g++) mwr(g, 1'b0, 32'hFFFF_FFFF);
    for (int k = 0; k < 7; k++) rd(5'(3*k), 32'h0, "R3 clear all");

    // configure: source i gets mode i%8, route = bit3 of i
    mwr(0, 1'b1, 32'hAAAA_AAAA);
    mwr(1, 1'b1, 32'hCCCC_CCCC);
    mwr(2, 1'b1, 32'hF0F0_F0F0);
    mwr(3, 1'b1, 32'hFF00_FF00);
    mwr(5, 1'b1, 32'h00FF_FFFF);
    mwr(4, 1'b0, 32'h00FF_0000);
    rd(5'd12, 32'h0000_FFFF, "R5 wake after mask set and wake clear");
    check_all("cfg");

    // R2 R4 R7 input pattern sweep
    apply(32'hFFFF_FFFF); check_all("p1");
    apply(32'h0000_0000); check_all("p2");
    wr(5'd25, 32'h0000_FFFF); m_rise &= 32'hFFFF_0000; m_fall &= 32'hFFFF_0000;
    check_all("ack");
    apply(32'h5555_5555); check_all("p3");
    apply(32'hFFFF_FFFF); check_all("p4");
    wr(5'd22, 32'hFFFF_0000); m_rise &= 32'h0000_FFFF; check_all("riseclr");
    apply(32'hA5A5_3C3C); check_all("p5");
    wr(5'd24, 32'h00FF_FF00); m_fall &= ~32'h00FF_FF00; check_all("fallclr");
    apply(32'h0000_0000); check_all("p6");

    // R4 edge in the same cycle as its clear stays latched
    wr(5'd25, 32'hFFFF_FFFF); m_rise = '0; m_fall = '0;
    src_i = 32'h0000_0002;
    tick();
    tick();
    wr(5'd22, 32'hFFFF_FFFF);
    rd(5'd21, 32'h0000_0002, "R4 edge during clear kept");
    wr(5'd25, 32'hFFFF_FFFF);
    rd(5'd21, 32'h0, "R4 ack clears");

    // R7 level latency: source 5 active-high, routed to output 1
    src_i = 32'h0000_0022;
    tick();
    bus_addr = 5'd27; #1;
    chk("R7 level not yet visible", bus_rdata & 32'h20, 32'h0);
    tick();
    bus_addr = 5'd27; #1;
    chk("R7 level visible after two edges", bus_rdata & 32'h20, 32'h20);
    src_i = 32'h0000_0002;
    repeat (2) tick();
    bus_addr = 5'd27; #1;
    chk("R7 level not latched", bus_rdata & 32'h20, 32'h0);

    // R9 test register and unmapped words
    wr(5'd28, 32'hDEAD_BEEF);
    rd(5'd28, 32'hDEAD_BEEF, "R9 test register");
    wr(5'd30, 32'hFFFF_FFFF);
    rd(5'd30, 32'h0, "R9 unmapped read");
    for (int k = 0; k < 7; k++) rd(5'(3*k), m_grp[k], "R9 unmapped write ignored");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule